// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects the interrupt requests of many peripherals and a few non-maskable trap requests, and turns them into one request line to a CPU. Each request is caught in a pending flag. At a fixed rate, the block picks one winner among the pending flags and registers four things: the request line, the winner's vector index, the winner's priority, and the program-memory address of the winner's vector entry. Traps always win over peripheral sources. Among the sources, the programmed level decides first, and ties go to the lower index.

The CPU takes the registered result and raises `ack`. On that same clock edge the winner's pending flag clears and the next winner, if there is one, is loaded. A control input moves every lookup from the primary vector table to an alternate table, which has the same layout and sits right after the primary one. The block does not fetch vector contents and does not handle reset vectoring.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, `irq` is 0 and `vec_idx`, `vec_prio` and `vec_addr` are all 0.
- R2: A source takes part only when its pending flag is set, its enable bit is 1 and its level is greater than `cpu_ipl`. Level 0 never raises a request, and neither does a level equal to `cpu_ipl`.
- R3: Among eligible sources, the one with the highest programmed level wins.
- R4: When eligible sources share the same level, the one with the lower index wins.
- R5: A pending trap wins over every source. Traps ignore `src_en` and `cpu_ipl`, the lowest pending trap index wins, and a trap reports `vec_prio` = 2^PRIO_W (8 by default).
- R6: Vector indices run 0..N_TRAP-1 for traps 0..N_TRAP-1, and N_TRAP+s for source s. With the defaults, source 5 has index 13.
- R7: `vec_addr` = base + 2*`vec_idx`. The base is PRI_BASE (0x000004) when `alt_sel` was 0 at the selection edge, and ALT_BASE (0x000100 by default, right after the 126 primary entries) when it was 1.
- R8: A request sampled on one rising edge shows up on the outputs at the next rising edge. This latency is the same for every source and every trap.
- R9: While `irq` is 1 and `ack` is 0, `irq`, `vec_idx`, `vec_prio` and `vec_addr` hold their values, even if a higher-priority request arrives.
- R10: An edge with `ack` = 1 and `irq` = 1 does two things. It clears the current winner's pending flag, and on that same edge the outputs move to the next winner among the remaining pending flags.
- R11: When nothing is eligible, `irq` is 0 and `vec_idx`, `vec_prio` and `vec_addr` keep their last values. A pending flag that is not yet eligible stays set until it becomes eligible and is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_req | input | N_SRC | Per-source request; a high sample sets the pending flag |
| src_en | input | N_SRC | Per-source enable |
| src_prio | input | N_SRC*PRIO_W | Source s level in bits [s*PRIO_W +: PRIO_W]; 0 disables |
| trap_req | input | N_TRAP | Trap requests; a high sample sets the trap pending flag |
| cpu_ipl | input | PRIO_W | CPU current priority level |
| alt_sel | input | 1 | 1 selects the alternate vector table |
| ack | input | 1 | CPU acknowledge of the registered winner |
| irq | output | 1 | Interrupt request to the CPU |
| vec_idx | output | IDX_W | Winning vector index |
| vec_prio | output | PRIO_W+1 | Winner's level; 2^PRIO_W for a trap |
| vec_addr | output | ADDR_W | Address of the winner's vector entry |

## Verification
Some internal faults show up at the ports on the very next edge after a request or an acknowledge:
- A wrong pending flag, either one left set after an acknowledge or a request that was lost, gives a wrong `vec_idx` at the next selection.
- A broken comparison of levels or of indices shows up as the wrong winner as soon as two sources compete.
- A wrong table base or stride shows up in `vec_addr` in the same cycle as the index.

A cycle-accurate model in the bench follows the pending flags, so a stale flag is caught when it wrongly wins, even many cycles after it went stale.

// File: rtl/vic_pkg.sv
package vic_pkg;
   // address units occupied by one vector entry
   localparam int unsigned VIC_STRIDE = 2;

   function automatic int unsigned vic_idx_w(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/vic_trap_encoder.sv
module vic_trap_encoder #(
   parameter int unsigned N_TRAP = 8,
   localparam int unsigned TW = vic_pkg::vic_idx_w(N_TRAP)
) (
   input  logic [N_TRAP-1:0] pend,
   output logic              found,
   output logic [TW-1:0]     win
);
   // lowest index wins: scan downward so the last hit is the lowest
   always_comb begin
      found = 1'b0;
      win   = '0;
      for (int i = N_TRAP - 1; i >= 0; i--) begin
         if (pend[i]) begin
            found = 1'b1;
            win   = TW'(i);
         end
      end
   end
endmodule

// File: rtl/vic_src_arbiter.sv
module vic_src_arbiter #(
   parameter int unsigned N      = 118,
   parameter int unsigned PW     = 3,
   localparam int unsigned SW    = vic_pkg::vic_idx_w(N)
) (
   input  logic [N-1:0]    pend,
   input  logic [N-1:0]    en,
   input  logic [N*PW-1:0] prio_flat,
   input  logic [PW-1:0]   ipl,
   output logic            found,
   output logic [SW-1:0]   win,
   output logic [PW-1:0]   win_prio
);
   logic [PW-1:0] lvl;

   // downward scan with >= keeps the lowest index among equal levels
   always_comb begin
      found    = 1'b0;
      win      = '0;
      win_prio = '0;
      lvl      = '0;
      for (int i = N - 1; i >= 0; i--) begin
         lvl = prio_flat[i*PW +: PW];
         if (pend[i] && en[i] && (lvl != '0) && (lvl > ipl) && (lvl >= win_prio)) begin
            found    = 1'b1;
            win      = SW'(i);
            win_prio = lvl;
         end
      end
   end
endmodule

// File: rtl/vic_addr_gen.sv
module vic_addr_gen #(
   parameter int unsigned ADDR_W   = 24,
   parameter int unsigned IDX_W    = 7,
   parameter int unsigned PRI_BASE = 4,
   parameter int unsigned ALT_BASE = 256,
   parameter bit          ALT_EN   = 1'b1
) (
   input  logic              alt_sel,
   input  logic [IDX_W-1:0]  idx,
   output logic [ADDR_W-1:0] addr
);
   logic [ADDR_W-1:0] offset;
   assign offset = ADDR_W'(idx) * ADDR_W'(vic_pkg::VIC_STRIDE);

   generate
      if (ALT_EN) begin : g_dual
         assign addr = (alt_sel ? ADDR_W'(ALT_BASE) : ADDR_W'(PRI_BASE)) + offset;
      end else begin : g_single
         logic unused_alt;
         assign unused_alt = alt_sel;
         assign addr = ADDR_W'(PRI_BASE) + offset;
      end
   endgenerate
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
   parameter int unsigned N_TRAP   = 8,
   parameter int unsigned N_SRC    = 118,
   parameter int unsigned PRIO_W   = 3,
   parameter int unsigned ADDR_W   = 24,
   parameter int unsigned PRI_BASE = 4,
   parameter int unsigned ALT_BASE = PRI_BASE + vic_pkg::VIC_STRIDE * (N_TRAP + N_SRC),
   parameter bit          ALT_EN   = 1'b1,
   localparam int unsigned N_VEC   = N_TRAP + N_SRC,
   localparam int unsigned IDX_W   = vic_pkg::vic_idx_w(N_VEC),
   localparam int unsigned TW      = vic_pkg::vic_idx_w(N_TRAP),
   localparam int unsigned SW      = vic_pkg::vic_idx_w(N_SRC)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [N_SRC-1:0]         src_req,
   input  logic [N_SRC-1:0]         src_en,
   input  logic [N_SRC*PRIO_W-1:0]  src_prio,
   input  logic [N_TRAP-1:0]        trap_req,
   input  logic [PRIO_W-1:0]        cpu_ipl,
   input  logic                     alt_sel,
   input  logic                     ack,
   output logic                     irq,
   output logic [IDX_W-1:0]         vec_idx,
   output logic [PRIO_W:0]          vec_prio,
   output logic [ADDR_W-1:0]        vec_addr
);
   localparam logic [PRIO_W:0] TRAP_LVL = (PRIO_W+1)'(1) << PRIO_W;

   // elaboration-time parameter checks
   if (N_TRAP < 1)  begin : g_bad_trap  $error("N_TRAP must be at least 1");  end
   if (N_SRC < 1)   begin : g_bad_src   $error("N_SRC must be at least 1");   end
   if (PRIO_W < 1)  begin : g_bad_prio  $error("PRIO_W must be at least 1");  end
   if (ADDR_W < 8 || ADDR_W > 31) begin : g_bad_addr $error("ADDR_W out of range"); end
   if (ALT_EN && (ALT_BASE < PRI_BASE + vic_pkg::VIC_STRIDE * N_VEC))
      begin : g_bad_alt $error("alternate table overlaps the primary table"); end

   logic [N_TRAP-1:0] tpend, tclr, tpend_m;
   logic [N_SRC-1:0]  spend, sclr, spend_m;
   logic              take, upd;

   assign take = ack && irq;
   assign upd  = !irq || ack;

   // one-hot clear of the registered winner
   for (genvar t = 0; t < N_TRAP; t++) begin : g_tclr
      assign tclr[t] = take && (vec_idx == IDX_W'(t));
   end
   for (genvar s = 0; s < N_SRC; s++) begin : g_sclr
      assign sclr[s] = take && (vec_idx == IDX_W'(N_TRAP + s));
   end

   assign tpend_m = tpend & ~tclr;
   assign spend_m = spend & ~sclr;

   logic          t_found, s_found;
   logic [TW-1:0] t_win;
   logic [SW-1:0] s_win;
   logic [PRIO_W-1:0] s_prio;

   vic_trap_encoder #(.N_TRAP(N_TRAP)) u_trap (
      .pend  (tpend_m),
      .found (t_found),
      .win   (t_win)
   );

   vic_src_arbiter #(.N(N_SRC), .PW(PRIO_W)) u_src (
      .pend      (spend_m),
      .en        (src_en),
      .prio_flat (src_prio),
      .ipl       (cpu_ipl),
      .found     (s_found),
      .win       (s_win),
      .win_prio  (s_prio)
   );

   logic              nxt_found;
   logic [IDX_W-1:0]  nxt_idx;
   logic [PRIO_W:0]   nxt_prio;
   logic [ADDR_W-1:0] nxt_addr;

   always_comb begin
      nxt_found = t_found || s_found;
      if (t_found) begin
         nxt_idx  = IDX_W'(t_win);
         nxt_prio = TRAP_LVL;
      end else begin
         nxt_idx  = IDX_W'(N_TRAP) + IDX_W'(s_win);
         nxt_prio = {1'b0, s_prio};
      end
   end

   vic_addr_gen #(
      .ADDR_W   (ADDR_W),
      .IDX_W    (IDX_W),
      .PRI_BASE (PRI_BASE),
      .ALT_BASE (ALT_BASE),
      .ALT_EN   (ALT_EN)
   ) u_addr (
      .alt_sel (alt_sel),
      .idx     (nxt_idx),
      .addr    (nxt_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tpend    <= '0;
         spend    <= '0;
         irq      <= 1'b0;
         vec_idx  <= '0;
         vec_prio <= '0;
         vec_addr <= '0;
      end else begin
         tpend <= tpend_m | trap_req;
         spend <= spend_m | src_req;
         if (upd) begin
            irq <= nxt_found;
            if (nxt_found) begin
               vec_idx  <= nxt_idx;
               vec_prio <= nxt_prio;
               vec_addr <= nxt_addr;
            end
         end
      end
   end

   // R9: outputs frozen while waiting for acknowledge
   a_r9_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !ack) |=> (irq && $stable(vec_idx) && $stable(vec_prio) && $stable(vec_addr)));

   // R5: a trap left pending at a selection edge always wins it
   a_r5_trap_first: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && (|tpend_m)) |=> (irq && vec_prio == TRAP_LVL));

   // R6: trap level appears exactly with trap indices
   a_r6_index_class: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ((vec_prio == TRAP_LVL) == (vec_idx < IDX_W'(N_TRAP))));

   // R2: source winner is always above the CPU level
   a_r2_above_ipl: assert property (@(posedge clk) disable iff (!rst_n)
      s_found |-> (s_prio > cpu_ipl && s_prio != '0));
endmodule

// File: tb/tb_vec_irq_ctrl.sv
module tb_vec_irq_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int NT = 8;
   localparam int NS = 118;
   localparam int NV = NT + NS;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NS-1:0]   src_req = '0;
   logic [NS-1:0]   src_en = '0;
   logic [NS*3-1:0] src_prio;
   logic [NT-1:0]   trap_req = '0;
   logic [2:0]      cpu_ipl = '0;
   logic            alt_sel = 1'b0;
   logic            ack = 1'b0;
   logic            irq;
   logic [6:0]      vec_idx;
   logic [3:0]      vec_prio;
   logic [23:0]     vec_addr;

   logic [2:0] lvl [NS];
   always_comb for (int i = 0; i < NS; i++) src_prio[i*3 +: 3] = lvl[i];

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vec_irq_ctrl dut (
      .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_en(src_en),
      .src_prio(src_prio), .trap_req(trap_req), .cpu_ipl(cpu_ipl),
      .alt_sel(alt_sel), .ack(ack), .irq(irq), .vec_idx(vec_idx),
      .vec_prio(vec_prio), .vec_addr(vec_addr)
   );

   // cycle model built from the requirements
   bit [NV-1:0] mp;
   bit m_irq;
   int m_idx, m_prio, m_addr;

   function automatic void pick(input bit [NV-1:0] p, output bit f, output int idx, output int pr);
      f = 0; idx = 0; pr = 0;
      for (int t = 0; t < NT; t++)
         if (p[t] && !f) begin f = 1; idx = t; pr = 8; end
      if (f) return;
      for (int s = 0; s < NS; s++)
         if (p[NT+s] && src_en[s] && lvl[s] != 0 && int'(lvl[s]) > int'(cpu_ipl) && int'(lvl[s]) > pr) begin
            f = 1; idx = NT + s; pr = int'(lvl[s]);
         end
   endfunction

   always @(posedge clk or negedge rst_n) begin
      bit [NV-1:0] p;
      bit f;
      int i, pr;
      if (!rst_n) begin
         mp = '0; m_irq = 0; m_idx = 0; m_prio = 0; m_addr = 0;
      end else begin
         p = mp;
         if (ack && m_irq) p[m_idx] = 1'b0;
         if (!m_irq || ack) begin
            pick(p, f, i, pr);
            m_irq = f;
            if (f) begin
               m_idx = i; m_prio = pr;
               m_addr = (alt_sel ? 256 : 4) + 2 * i;
            end
         end
         mp = p | {src_req, trap_req};
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic chk_model(input string tag);
      chk({tag, " irq"}, int'(irq), int'(m_irq));
      chk({tag, " idx"}, int'(vec_idx), m_idx);
      chk({tag, " prio"}, int'(vec_prio), m_prio);
      chk({tag, " R7 addr"}, int'(vec_addr), m_addr);
   endtask

   task automatic step(); @(posedge clk); @(negedge clk); endtask

   task automatic pulse_src(input int s);
      src_req[s] = 1'b1; step(); src_req[s] = 1'b0;
   endtask

   task automatic do_ack();
      ack = 1'b1; step(); ack = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int seed;
      seed = $urandom(32'd2024);
      for (int i = 0; i < NS; i++) lvl[i] = 3'd0;
      repeat (3) @(negedge clk);
      chk("R1 irq", int'(irq), 0);
      chk("R1 idx", int'(vec_idx), 0);
      chk("R1 prio", int'(vec_prio), 0);
      chk("R1 addr", int'(vec_addr), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: level 0 and level equal to ipl never fire
      src_en[5] = 1'b1; cpu_ipl = 3'd3;
      pulse_src(5); step();
      chk("R2 level0 irq", int'(irq), 0);
      lvl[5] = 3'd3; step();
      chk("R2 equal-ipl irq", int'(irq), 0);
      // R11: pending flag kept, fires once eligible
      cpu_ipl = 3'd2; step();
      chk("R11 kept pending irq", int'(irq), 1);
      chk("R6 idx src5", int'(vec_idx), 13);
      chk("R7 primary addr", int'(vec_addr), 24'h1E);

      // R9: a higher source arriving does not disturb the held winner
      src_en[0] = 1'b1; lvl[0] = 3'd7;
      pulse_src(0); step();
      chk("R9 hold idx", int'(vec_idx), 13);
      chk("R9 hold prio", int'(vec_prio), 3);
      // R10: ack moves to next winner on the same edge
      do_ack();
      chk("R10 next idx", int'(vec_idx), 8);
      chk("R10 next prio", int'(vec_prio), 7);
      do_ack();
      chk("R11 idle irq", int'(irq), 0);
      chk("R11 idle idx holds", int'(vec_idx), 8);

      // R4: equal levels, lower index wins
      cpu_ipl = 3'd0;
      src_en[3] = 1'b1; src_en[9] = 1'b1; lvl[3] = 3'd4; lvl[9] = 3'd4;
      src_req[3] = 1'b1; src_req[9] = 1'b1;
      step();
      src_req[3] = 1'b0; src_req[9] = 1'b0;
      chk("R8 not yet irq", int'(irq), 0);
      step();
      chk("R8 latency irq", int'(irq), 1);
      chk("R4 tie idx", int'(vec_idx), 11);
      do_ack();
      chk("R4 second idx", int'(vec_idx), 17);
      do_ack();

      // R3: higher level wins over lower index
      src_en[20] = 1'b1; lvl[20] = 3'd2; src_en[40] = 1'b1; lvl[40] = 3'd6;
      src_req[20] = 1'b1; src_req[40] = 1'b1; step();
      src_req[20] = 1'b0; src_req[40] = 1'b0; step();
      chk("R3 winner idx", int'(vec_idx), 48);
      do_ack();
      chk("R3 then idx", int'(vec_idx), 28);
      do_ack();

      // R5: traps ignore enable and ipl, lowest trap first
      cpu_ipl = 3'd7; src_en = '0;
      trap_req[6] = 1'b1; trap_req[2] = 1'b1; step();
      trap_req = '0; step();
      chk("R5 trap irq", int'(irq), 1);
      chk("R5 trap idx", int'(vec_idx), 2);
      chk("R5 trap prio", int'(vec_prio), 8);
      chk("R7 trap addr", int'(vec_addr), 8);
      do_ack();
      chk("R5 next trap idx", int'(vec_idx), 6);
      do_ack();

      // R7: alternate table
      alt_sel = 1'b1;
      trap_req[1] = 1'b1; step(); trap_req = '0; step();
      chk("R7 alt addr", int'(vec_addr), 24'h102);
      do_ack();
      alt_sel = 1'b0;
      chk_model("R11 directed end");

      // random phase against the model
      for (int i = 0; i < NS; i++) begin
         lvl[i] = 3'($urandom % 8);
         src_en[i] = ($urandom % 4) != 0;
      end
      cpu_ipl = 3'd1;
      for (int c = 0; c < 3000; c++) begin
         src_req = '0; trap_req = '0;
         if ($urandom % 4 == 0) src_req[$urandom % NS] = 1'b1;
         if ($urandom % 6 == 0) src_req[$urandom % NS] = 1'b1;
         if ($urandom % 50 == 0) trap_req[$urandom % NT] = 1'b1;
         ack = ($urandom % 3) == 0;
         if ($urandom % 25 == 0) cpu_ipl = 3'($urandom % 8);
         if ($urandom % 60 == 0) alt_sel = ~alt_sel;
         if ($urandom % 200 == 0) lvl[$urandom % NS] = 3'($urandom % 8);
         step();
         chk_model("R3 random");
      end
      src_req = '0; trap_req = '0; ack = 1'b0;
      step();

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule